// File: doc/BRIEF.md
# Dual-Clock FIFO with Banded Occupancy Flags

This block is a first-in first-out buffer whose write side and read side run on separate clocks. Words enter on a write-clock edge while an active-low write enable is held and the buffer has room. Words leave on a read-clock edge while an active-low read enable is held and the buffer holds data. The word just read is kept in an output register. An active-low output enable either presents that word or forces the output bus to all zeros.

Four active-low status pins describe occupancy. Each pin merges a read-domain condition and a write-domain condition, and each condition is computed only from registers in its own domain. The read side judges emptiness, the low-occupancy band and reads attempted while empty. The write side judges fullness, the high-occupancy band, more-than-half occupancy and writes attempted while full. Pointers cross between the domains in Gray code through two-stage synchronisers, so every flag errs on the safe side. A fault pin records an illegal access and holds it until the blocking condition has gone. An active-low master reset empties the buffer from either side.

Top module: `dcfifo_flags`

## Requirements
- R1: On a write-clock edge where `wrEnN` is 0 and the write side does not see the buffer as full, `wrData` is stored. Holding `wrEnN` low stores one word on every edge. A write attempted while full is dropped.
- R2: On a read-clock edge where `rdEnN` is 0 and the read side does not see the buffer as empty, the output register loads the oldest stored word. In every other case the output register keeps its value.
- R3: Words leave in exactly the order in which they were accepted, with no loss and no duplication.
- R4: `efN` is 0 when the read-side count is 0 or the write-side count equals DEPTH. Otherwise it is 1.
- R5: `qtN` is 0 when the read-side count is at most DEPTH/4 or the write-side count is at least DEPTH - DEPTH/4. Otherwise it is 1.
- R6: `hfN` is 0 when the write-side count is greater than DEPTH/2. Otherwise it is 1.
- R7: A write-clock edge with `wrEnN` at 0 while the write side sees full sets the full fault, which drives `faultN` to 0. The fault remains set on every write edge at which full is still seen. It clears at the first write edge at which full is no longer seen.
- R8: A read-clock edge with `rdEnN` at 0 while the read side sees empty sets the empty fault, which drives `faultN` to 0. The fault remains set while empty is seen and clears at the first read edge that does not see empty.
- R9: While `mrN` is 0, the buffer is empty, both faults are clear and the output register holds 0. With nothing stored, the pins then read `efN`=0, `qtN`=0, `hfN`=1 and `faultN`=1.
- R10: While `oeN` is 1, `rdData` is all zeros. While `oeN` is 0, `rdData` shows the output register.
- R11: An accepted write becomes visible to the read-side count after two read-clock edges. An accepted read becomes visible to the write-side count after two write-clock edges. Each Gray pointer changes at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| mrN | input | 1 | Active-low master reset, asynchronous to both domains |
| wrEnN | input | 1 | Active-low write enable |
| wrData | input | DATA_W | Word to store |
| rdEnN | input | 1 | Active-low read enable |
| oeN | input | 1 | Active-low output enable |
| rdData | output | DATA_W | Output register, or zeros while disabled |
| efN | output | 1 | Low when empty (read side) or full (write side) |
| qtN | output | 1 | Low in the lowest or highest occupancy band |
| hfN | output | 1 | Low when more than half full (write side) |
| faultN | output | 1 | Low while an empty fault or a full fault is latched |

## Verification
Some properties hold on every cycle, and assertions placed beside the pointer logic check them there. Neither domain's count may exceed DEPTH. A pointer stays put while its domain sees full or empty. Each Gray pointer steps by one bit at most. Each fault sets on an illegal access and drops once its condition has gone.

Other behaviour only shows up across a whole stimulus sequence, and the bench scenarios cover it. That includes word ordering, the exact edge on which each banded pin moves given the two-edge synchroniser delay, and fault release after draining or filling. It also covers output gating and a reset issued while the buffer holds data.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  // Strobes handed from the pointer control to the storage datapath.
  typedef struct packed {
    logic wrStb;  // store wrData at the write address this write edge
    logic rdStb;  // load output register from the read address this read edge
  } strobeT;

endpackage

// File: rtl/dcfifo_sync.sv
// Two-stage synchroniser for a Gray pointer, with Gray-to-binary decode
// performed on the synchronised value in the destination domain.
module dcfifo_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] binOut
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= grayIn;
      stage2 <= stage1;
    end
  end

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      acc       = acc ^ stage2[i];
      binOut[i] = acc;
    end
  end

endmodule

// File: rtl/dcfifo_ctrl.sv
// Pointer control and per-domain flag logic.
module dcfifo_ctrl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrN,
  input  logic              wrEnN,
  input  logic              rdEnN,
  output strobeT            stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              emptyR,
  output logic              quarterR,
  output logic              faultR,
  output logic              fullW,
  output logic              threeQW,
  output logic              halfW,
  output logic              faultW
);

  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] FULL_C = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [PW-1:0] HALF_C = FULL_C >> 1;
  localparam logic [PW-1:0] QTR_C  = FULL_C >> 2;
  localparam logic [PW-1:0] TQ_C   = FULL_C - QTR_C;

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrBinNext, wrGray, rdBinW, wrCount;
  logic          wrGo;

  dcfifo_sync #(.W(PW)) u_rdToWr (
    .clk    (wrClk),
    .rstN   (mrN),
    .grayIn (rdGray),
    .binOut (rdBinW)
  );

  assign wrCount   = wrBin - rdBinW;
  assign fullW     = (wrCount == FULL_C);
  assign threeQW   = (wrCount >= TQ_C);
  assign halfW     = (wrCount > HALF_C);
  assign wrGo      = ~wrEnN & ~fullW;
  assign wrBinNext = wrBin + {{(PW-1){1'b0}}, wrGo};

  always_ff @(posedge wrClk or negedge mrN) begin
    if (!mrN) begin
      wrBin  <= '0;
      wrGray <= '0;
      faultW <= 1'b0;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= wrBinNext ^ (wrBinNext >> 1);
      faultW <= fullW ? (faultW | ~wrEnN) : 1'b0;
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, rdBinNext, rdGray, wrBinR, rdCount;
  logic          rdGo;

  dcfifo_sync #(.W(PW)) u_wrToRd (
    .clk    (rdClk),
    .rstN   (mrN),
    .grayIn (wrGray),
    .binOut (wrBinR)
  );

  assign rdCount   = wrBinR - rdBin;
  assign emptyR    = (rdCount == '0);
  assign quarterR  = (rdCount <= QTR_C);
  assign rdGo      = ~rdEnN & ~emptyR;
  assign rdBinNext = rdBin + {{(PW-1){1'b0}}, rdGo};

  always_ff @(posedge rdClk or negedge mrN) begin
    if (!mrN) begin
      rdBin  <= '0;
      rdGray <= '0;
      faultR <= 1'b0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= rdBinNext ^ (rdBinNext >> 1);
      faultR <= emptyR ? (faultR | ~rdEnN) : 1'b0;
    end
  end

  assign stb.wrStb = wrGo;
  assign stb.rdStb = rdGo;
  assign wrAddr    = wrBin[ADDR_W-1:0];
  assign rdAddr    = rdBin[ADDR_W-1:0];

  // ---------------- assertions ----------------
  assert_no_overflow_R1: assert property (@(posedge wrClk) disable iff (!mrN)
    wrCount <= FULL_C);
  assert_wr_hold_full_R1: assert property (@(posedge wrClk) disable iff (!mrN)
    fullW |=> $stable(wrBin));
  assert_no_underflow_R2: assert property (@(posedge rdClk) disable iff (!mrN)
    rdCount <= FULL_C);
  assert_rd_hold_empty_R2: assert property (@(posedge rdClk) disable iff (!mrN)
    emptyR |=> $stable(rdBin));
  assert_full_fault_set_R7: assert property (@(posedge wrClk) disable iff (!mrN)
    (fullW && !wrEnN) |=> faultW);
  assert_full_fault_clear_R7: assert property (@(posedge wrClk) disable iff (!mrN)
    !fullW |=> !faultW);
  assert_empty_fault_set_R8: assert property (@(posedge rdClk) disable iff (!mrN)
    (emptyR && !rdEnN) |=> faultR);
  assert_empty_fault_clear_R8: assert property (@(posedge rdClk) disable iff (!mrN)
    !emptyR |=> !faultR);
  assert_wr_gray_step_R11: assert property (@(posedge wrClk) disable iff (!mrN)
    1'b1 |=> ($countones(wrGray ^ $past(wrGray)) <= 1));
  assert_rd_gray_step_R11: assert property (@(posedge rdClk) disable iff (!mrN)
    1'b1 |=> ($countones(rdGray ^ $past(rdGray)) <= 1));

endmodule

// File: rtl/dcfifo_store.sv
// Storage array, output register and output gating.
module dcfifo_store
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 10
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrN,
  input  strobeT            stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              oeN,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge mrN) begin
    if (!mrN)           rdQ <= '0;
    else if (stb.rdStb) rdQ <= mem[rdAddr];
  end

  assign rdData = oeN ? '0 : rdQ;

endmodule

// File: rtl/dcfifo_flags.sv
// Top: joins control and datapath, merges per-domain flags onto pins.
module dcfifo_flags
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 10
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrN,
  input  logic              wrEnN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEnN,
  input  logic              oeN,
  output logic [DATA_W-1:0] rdData,
  output logic              efN,
  output logic              qtN,
  output logic              hfN,
  output logic              faultN
);

  strobeT            stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              emptyR, quarterR, faultR;
  logic              fullW, threeQW, halfW, faultW;

  dcfifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .mrN      (mrN),
    .wrEnN    (wrEnN),
    .rdEnN    (rdEnN),
    .stb      (stb),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .emptyR   (emptyR),
    .quarterR (quarterR),
    .faultR   (faultR),
    .fullW    (fullW),
    .threeQW  (threeQW),
    .halfW    (halfW),
    .faultW   (faultW)
  );

  dcfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .wrClk  (wrClk),
    .rdClk  (rdClk),
    .mrN    (mrN),
    .stb    (stb),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .wrData (wrData),
    .oeN    (oeN),
    .rdData (rdData)
  );

  assign efN    = ~(emptyR | fullW);
  assign qtN    = ~(quarterR | threeQW);
  assign hfN    = ~halfW;
  assign faultN = ~(faultR | faultW);

endmodule

// File: tb/dcfifo_flags_tb.sv
module dcfifo_flags_tb_top;

  localparam int DATA_W = 36;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int QTR    = DEPTH / 4;
  localparam int HALF   = DEPTH / 2;
  localparam int TQ     = DEPTH - QTR;

  logic              clk = 1'b0;
  logic              mrN = 1'b0;
  logic              wrEnN = 1'b1;
  logic              rdEnN = 1'b1;
  logic              oeN = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              efN, qtN, hfN, faultN;

  int checks = 0;
  int errors = 0;
  int seq = 0;

  // behavioural model state
  int wrTot, rdTot, wrD1, wrD2, rdD1, rdD2;
  bit fW, fR;
  logic [DATA_W-1:0] lastRd;
  logic [DATA_W-1:0] q[$];

  always #4 clk = ~clk;  // 125 MHz, both domains on one clock

  dcfifo_flags #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .wrClk  (clk),
    .rdClk  (clk),
    .mrN    (mrN),
    .wrEnN  (wrEnN),
    .wrData (wrData),
    .rdEnN  (rdEnN),
    .oeN    (oeN),
    .rdData (rdData),
    .efN    (efN),
    .qtN    (qtN),
    .hfN    (hfN),
    .faultN (faultN)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int wS, rS;
    wS = wrTot - rdD2;
    rS = wrD2 - rdTot;
    chk("R2 R3 R10 rdData", 64'(rdData), oeN ? 64'd0 : 64'(lastRd));
    chk("R4 efN", 64'(efN), 64'(!((rS == 0) || (wS == DEPTH))));
    chk("R5 qtN", 64'(qtN), 64'(!((rS <= QTR) || (wS >= TQ))));
    chk("R6 hfN", 64'(hfN), 64'(!(wS > HALF)));
    chk("R7 R8 faultN", 64'(faultN), 64'(!(fW || fR)));
  endtask

  task automatic modelReset();
    wrTot = 0; rdTot = 0; wrD1 = 0; wrD2 = 0; rdD1 = 0; rdD2 = 0;
    fW = 0; fR = 0; lastRd = '0;
    q.delete();
  endtask

  // R9: reset while inputs request activity
  task automatic doReset();
    mrN = 1'b0; wrEnN = 1'b0; rdEnN = 1'b0; oeN = 1'b0;
    @(posedge clk); #2;
    modelReset();
    compareAll();
    chk("R9 efN reset", 64'(efN), 64'd0);
    chk("R9 faultN reset", 64'(faultN), 64'd1);
    mrN = 1'b1; wrEnN = 1'b1; rdEnN = 1'b1;
  endtask

  task automatic step(bit we, bit re, bit oe);
    int wS, rS;
    bit fullB, emptyB, wa, ra;
    wrEnN = !we; rdEnN = !re; oeN = !oe;
    seq++;
    wrData = DATA_W'(seq) * 36'h0_9E37_79B1 + 36'hA_5A5A_0000;
    @(posedge clk); #2;
    wS = wrTot - rdD2;
    rS = wrD2 - rdTot;
    fullB  = (wS == DEPTH);
    emptyB = (rS == 0);
    wa = we && !fullB;   // R1
    ra = re && !emptyB;  // R2
    fW = fullB ? (fW || we) : 1'b0;   // R7
    fR = emptyB ? (fR || re) : 1'b0;  // R8
    if (ra) lastRd = q.pop_front();   // R3
    if (wa) q.push_back(wrData);
    // R11: two-edge visibility across domains
    wrD2 = wrD1; wrD1 = wrTot; wrTot += int'(wa);
    rdD2 = rdD1; rdD1 = rdTot; rdTot += int'(ra);
    compareAll();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    modelReset();
    doReset();
    for (int i = 0; i < 3; i++) step(0, 0, 1);

    // R1 R5: five writes then idle; then read back in order (R2 R3)
    for (int i = 0; i < 5; i++) step(1, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 1);
    for (int i = 0; i < 7; i++) step(0, 1, 1);  // last two read empty -> R8
    for (int i = 0; i < 3; i++) step(0, 0, 1);

    // R1 R6 R7: continuous writes past full, fault latched
    for (int i = 0; i < DEPTH + 4; i++) step(1, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    step(1, 0, 1);                               // another write while full
    step(0, 1, 1);                               // R7: read one, full clears later
    for (int i = 0; i < 4; i++) step(0, 0, 1);
    // R10: drain with output disabled part of the time
    for (int i = 0; i < DEPTH + 3; i++) step(0, 1, (i % 4) != 1);
    for (int i = 0; i < 4; i++) step(0, 0, 1);
    step(0, 0, 0);
    step(0, 0, 1);

    // R3 R11: streaming with mixed enables
    for (int i = 0; i < 60; i++) step((i % 3) != 0, (i % 5) != 2, 1);
    for (int i = 0; i < 40; i++) step(1, (i % 4) == 0, 1);
    for (int i = 0; i < 40; i++) step((i % 6) == 0, 1, 1);

    // R9: reset while holding data
    for (int i = 0; i < 10; i++) step(1, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    doReset();
    for (int i = 0; i < 4; i++) step(0, 1, 1);
    for (int i = 0; i < 6; i++) step(1, 1, 1);
    for (int i = 0; i < 8; i++) step(0, 1, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule